// File: doc/BRIEF.md
# Selectable Arithmetic Microoperation Unit

This block performs one arithmetic operation per clock on two W-bit operands and keeps the result in a destination register. Each operation has the form D = A + Y + Cin. Operand A goes straight into a ripple-carry adder. The second operand Y is picked by a 2-bit select: B, the bitwise inverse of B, all zeros, or all ones. The carry input enters at the least significant bit.

There is no opcode per operation. The operation is set by the select and the carry input together:

| Select | Y | Cin = 0 | Cin = 1 |
|---|---|---|---|
| 00 | B | add | add with carry |
| 01 | ~B | subtract with borrow | subtract |
| 10 | zeros | pass A | increment A |
| 11 | ones | decrement A | pass A |

The sum and its carry-out are written to the destination register only on edges where load is high. At other times the register holds its value. A control sequencer drives the select, the carry input and the load to build its register transfers.

Top module: `arith_mu`

## Requirements
- R1: While rst_ni is low, d_o and cout_o are 0.
- R2: With sel_i = 2'b00, a loaded result is d_o = (a_i + b_i + cin_i) mod 2^W. This is add when cin_i = 0 and add with carry when cin_i = 1.
- R3: With sel_i = 2'b01, a loaded result is d_o = (a_i + ~b_i + cin_i) mod 2^W. With cin_i = 1 this is a_i - b_i, and cout_o is 1 exactly when a_i >= b_i.
- R4: With sel_i = 2'b10, b_i is ignored and a loaded result is d_o = a_i + cin_i. Incrementing all ones gives d_o = 0 and cout_o = 1.
- R5: With sel_i = 2'b11, b_i is ignored and a loaded result is d_o = (a_i + 2^W - 1 + cin_i) mod 2^W. With cin_i = 0 this is a decrement, and its carry-out is 1 unless a_i = 0. With cin_i = 1, a_i passes through with cout_o = 1.
- R6: On a clock edge with load_i = 0, d_o and cout_o keep their previous values, whatever the other inputs do.
- R7: For every select, a loaded cout_o is bit W of the (W+1)-bit sum a_i + Y + cin_i.
- R8: A loaded result appears on the outputs after the first rising edge with load_i = 1. Before that edge, the outputs still show the previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Write the sum into the destination register |
| sel_i | input | 2 | Second-operand select (00 B, 01 ~B, 10 zeros, 11 ones) |
| cin_i | input | 1 | Carry into the least significant bit |
| a_i | input | W | First operand, fed directly to the adder |
| b_i | input | W | Source for the second operand |
| d_o | output | W | Destination register |
| cout_o | output | 1 | Registered carry-out |

## Verification
At W = 4, the bench sweeps every combination of select, carry input, A and B. This covers every carry chain, from no carry to a carry that ripples through all bits.

Comparing the results for the two values of cin_i under one select checks that the carry enters at the least significant position. Sweeping B under selects 10 and 11 shows that B is ignored there.

Loads with load_i low and changing inputs separate a register that holds from one that follows its inputs. Sampling just before a loading edge confirms the one-cycle latency. Named corner cases are checked on their own: all ones incremented, zero decremented, and A equal to B under subtraction.

// File: rtl/arith_mu_pkg.sv
package arith_mu_pkg;
  typedef enum logic [1:0] {
    YSEL_B    = 2'b00,
    YSEL_NOTB = 2'b01,
    YSEL_ZERO = 2'b10,
    YSEL_ONES = 2'b11
  } ysel_e;
endpackage

// File: rtl/arith_mu_ysel.sv
module arith_mu_ysel
  import arith_mu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [1:0]   sel_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  ysel_e sel;
  assign sel = ysel_e'(sel_i);

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      unique case (sel)
        YSEL_B:    y_o[i] = b_i[i];
        YSEL_NOTB: y_o[i] = ~b_i[i];
        YSEL_ZERO: y_o[i] = 1'b0;
        default:   y_o[i] = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/arith_mu_adder.sv
module arith_mu_adder #(
  parameter int W = 4
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  output logic [W-1:0] s_o,
  output logic         cout_o
);
  logic [W:0] c;
  assign c[0] = cin_i;

  for (genvar i = 0; i < W; i++) begin : g_fa
    logic p;
    assign p        = x_i[i] ^ y_i[i];
    assign s_o[i]   = p ^ c[i];
    assign c[i+1]   = (x_i[i] & y_i[i]) | (p & c[i]);
  end

  assign cout_o = c[W];
endmodule

// File: rtl/arith_mu_dreg.sv
module arith_mu_dreg #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  input  logic         c_i,
  output logic [W-1:0] q_o,
  output logic         c_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= '0;
      c_o <= 1'b0;
    end else if (en_i) begin
      q_o <= d_i;
      c_o <= c_i;
    end
  end
endmodule

// File: rtl/arith_mu.sv
module arith_mu #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [1:0]   sel_i,
  input  logic         cin_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] d_o,
  output logic         cout_o
);
  logic [W-1:0] y;
  logic [W-1:0] sum;
  logic         carry;

  arith_mu_ysel #(.W(W)) i_ysel (
    .sel_i (sel_i),
    .b_i   (b_i),
    .y_o   (y)
  );

  arith_mu_adder #(.W(W)) i_adder (
    .x_i    (a_i),
    .y_i    (y),
    .cin_i  (cin_i),
    .s_o    (sum),
    .cout_o (carry)
  );

  arith_mu_dreg #(.W(W)) i_dreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (load_i),
    .d_i    (sum),
    .c_i    (carry),
    .q_o    (d_o),
    .c_o    (cout_o)
  );
endmodule

// File: rtl/arith_mu_chk.sv
module arith_mu_chk #(
  parameter int W = 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         load_i,
  input logic [1:0]   sel_i,
  input logic         cin_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [W-1:0] d_o,
  input logic         cout_o
);
  function automatic logic [W:0] ref_sum(logic [1:0] s, logic c,
                                         logic [W-1:0] a, logic [W-1:0] b);
    logic [W-1:0] y;
    case (s)
      2'b00:   y = b;
      2'b01:   y = ~b;
      2'b10:   y = '0;
      default: y = '1;
    endcase
    return {1'b0, a} + {1'b0, y} + (W+1)'(c);
  endfunction

  always @(posedge clk_i)
    if (!rst_ni) AST_RST_CLEAR: assert (d_o == '0 && cout_o == 1'b0); // R1

  AST_ADD_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && sel_i == 2'b00) |=>
      ({cout_o, d_o} == ref_sum(2'b00, $past(cin_i), $past(a_i), $past(b_i)))); // R2

  AST_SUB_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && sel_i == 2'b01) |=>
      ({cout_o, d_o} == ref_sum(2'b01, $past(cin_i), $past(a_i), $past(b_i)))); // R3

  AST_INC_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && sel_i == 2'b10) |=>
      ({cout_o, d_o} == {1'b0, $past(a_i)} + (W+1)'($past(cin_i)))); // R4

  AST_DEC_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && sel_i == 2'b11) |=>
      ({cout_o, d_o} == ref_sum(2'b11, $past(cin_i), $past(a_i), $past(b_i)))); // R5

  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(d_o) && $stable(cout_o))); // R6
endmodule

bind arith_mu arith_mu_chk #(.W(W)) i_arith_mu_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .load_i (load_i),
  .sel_i  (sel_i),
  .cin_i  (cin_i),
  .a_i    (a_i),
  .b_i    (b_i),
  .d_o    (d_o),
  .cout_o (cout_o)
);

// File: tb/test_arith_mu.sv
module test_arith_mu;
  localparam int W = 4;
  localparam int N = 1 << W;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         load_i = 1'b0;
  logic [1:0]   sel_i = 2'b00;
  logic         cin_i = 1'b0;
  logic [W-1:0] a_i = '0;
  logic [W-1:0] b_i = '0;
  logic [W-1:0] d_o;
  logic         cout_o;

  int checks = 0;
  int failures = 0;

  always #4 clk_i = ~clk_i;

  arith_mu #(.W(W)) i_arith_mu (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .sel_i(sel_i),
    .cin_i(cin_i), .a_i(a_i), .b_i(b_i), .d_o(d_o), .cout_o(cout_o)
  );

  function automatic logic [W:0] expect_sum(int s, int c, int a, int b);
    int y;
    case (s)
      0:       y = b;
      1:       y = (N - 1) - b;
      2:       y = 0;
      default: y = N - 1;
    endcase
    return (W+1)'(a + y + c);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input bit ld, input int s, input int c, input int a, input int b);
    load_i = ld;
    sel_i  = 2'(s);
    cin_i  = 1'(c);
    a_i    = W'(a);
    b_i    = W'(b);
  endtask

  // drive at negedge, result visible by next negedge
  task automatic op(input int s, input int c, input int a, input int b,
                    output logic [W-1:0] d, output logic co);
    @(negedge clk_i);
    drive(1'b1, s, c, a, b);
    @(negedge clk_i);
    d  = d_o;
    co = cout_o;
  endtask

  initial begin
    logic [W-1:0] d;
    logic         co;
    logic [W:0]   e;
    string        tag;

    repeat (3) @(negedge clk_i);
    chk(d_o == 0, "R1 d_o in reset", int'(d_o), 0);
    chk(cout_o == 0, "R1 cout_o in reset", int'(cout_o), 0);
    rst_ni = 1'b1;

    // exhaustive sweep
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 2; c++)
        for (int a = 0; a < N; a++)
          for (int b = 0; b < N; b++) begin
            op(s, c, a, b, d, co);
            e = expect_sum(s, c, a, b);
            case (s)
              0: tag = "R2 add";
              1: tag = "R3 sub";
              2: tag = "R4 zero operand";
              default: tag = "R5 ones operand";
            endcase
            chk(d == e[W-1:0], tag, int'(d), int'(e[W-1:0]));
            chk(co == e[W], "R7 carry-out", int'(co), int'(e[W]));
          end

    // corner cases
    op(2, 1, N - 1, 5, d, co);
    chk(d == 0 && co == 1, "R4 increment all ones", int'({co, d}), N);
    op(3, 0, 0, 9, d, co);
    chk(d == W'(N - 1) && co == 0, "R5 decrement zero", int'({co, d}), N - 1);
    op(3, 1, 6, 3, d, co);
    chk(d == 6 && co == 1, "R5 pass with cin", int'({co, d}), N + 6);
    op(1, 1, 7, 7, d, co);
    chk(d == 0 && co == 1, "R3 a equals b", int'({co, d}), N);
    op(1, 1, 3, 4, d, co);
    chk(d == W'(N - 1) && co == 0, "R3 borrow", int'({co, d}), N - 1);

    // hold with load low
    op(0, 0, 9, 4, d, co); // d=13 co=0
    for (int k = 0; k < 6; k++) begin
      @(negedge clk_i);
      drive(1'b0, k % 4, k % 2, 15 - k, k * 3);
      @(negedge clk_i);
      chk(d_o == 13 && cout_o == 0, "R6 hold", int'({cout_o, d_o}), 13);
    end

    // latency
    @(negedge clk_i);
    drive(1'b1, 0, 1, 10, 10);
    #1;
    chk(d_o == 13, "R8 before edge", int'(d_o), 13);
    @(negedge clk_i);
    chk(d_o == 5 && cout_o == 1, "R8 after edge", int'({cout_o, d_o}), N + 5);
    load_i = 1'b0;

    // async reset clears
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk(d_o == 0 && cout_o == 0, "R1 reset clears", int'({cout_o, d_o}), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule